// File: doc/BRIEF.md
# Converter Power State Sequencer

This block decides which parts of a data converter are kept alive. Two configuration bits drive it: a power-down request and a depth select. With power-down clear, the converter runs normally. With power-down set, it drops into one of two save states. The shallow save state, standby, stops the digital filter but keeps the oscillator and the analog bias alive, so the return to normal is immediate. The deep save state, sleep, also stops the oscillator.

Because the oscillator is off in sleep, any way out of sleep passes through a warm-up phase. The oscillator runs during warm-up, but the block reports not-ready until a parameterised number of pulses from an always-on slow reference tick have been counted. When the converter is driven from an external clock, there is nothing to warm up and the phase is skipped. A soft-reset request forces the block back to normal operation. If the oscillator was off, the soft reset still has to wait out the warm-up first.

The state is held in registers, and the four enables are decoded from that state. An input change therefore shows up on the outputs one clock edge later.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters normal mode, whatever the other inputs are. In normal mode `filt_en`, `osc_en`, `bias_en` and `ready` are all 1.
- R2: In normal mode with `pd_req`=0 and `soft_rst`=0, the block stays in normal mode.
- R3: From normal mode, `pd_req`=1 with `deep_sel`=0 gives standby one edge later. Standby means `filt_en`=0, `osc_en`=1, `bias_en`=1 and `ready`=1. From standby, `pd_req`=0 gives normal mode on the next edge.
- R4: From normal mode, `pd_req`=1 with `deep_sel`=1 gives sleep one edge later. Sleep means all four outputs are 0.
- R5: In sleep with `ext_clk_sel`=0, a request that is no longer for sleep moves the block to warm-up on the next edge. Warm-up means `osc_en`=1 and the other three outputs 0. The block leaves warm-up on the edge that samples the WAIT_TICKS-th `ref_tick` pulse seen during warm-up, and goes to the state the inputs ask for.
- R6: With `ext_clk_sel`=1, leaving sleep goes straight to the requested state on the next edge. Asserting `ext_clk_sel` during warm-up ends warm-up on the next edge.
- R7: While in a save state, changing `deep_sel` moves between the two save states. Standby goes directly to sleep. Sleep goes to standby through warm-up.
- R8: `soft_rst`=1 in normal mode or standby gives normal mode on the next edge, even when `pd_req`=1. In sleep, or during warm-up, `soft_rst`=1 holds the block in warm-up until the wait ends, ignoring sleep requests, and then it enters normal mode.
- R9: `ref_tick` has no effect outside warm-up. During warm-up, a cycle without `ref_tick` does not advance the wait.
- R10: A sleep request during warm-up (with no soft reset pending) returns the block to sleep on the next edge. Each new warm-up counts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req | input | 1 | Power-down request bit from the configuration register |
| deep_sel | input | 1 | Save depth select: 0 standby, 1 sleep |
| ext_clk_sel | input | 1 | 1 when an external clock is used (no warm-up) |
| soft_rst | input | 1 | Soft-reset request, forces normal mode |
| ref_tick | input | 1 | One-cycle pulse from the always-on slow reference |
| filt_en | output | 1 | Filter computation enable |
| osc_en | output | 1 | Oscillator enable |
| bias_en | output | 1 | Analog bias enable |
| ready | output | 1 | Clock stable and block not waiting |

## Verification
The bench drives sequences of request bits and checks the four-bit output pattern that each state must show.

Moving normal to standby to normal separates the shallow save state from the deep one by looking at `osc_en` and `bias_en`. Leaving sleep with tick pulses spaced out, gaps included, shows that the wait counts ticks and not cycles. Aborting a warm-up and then restarting it shows that the count starts again from zero.

The external-clock cases, and soft reset issued from standby and from sleep, separate the immediate exits from the exits that must wait.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'd0,
        PM_IDLE = 2'd1,
        PM_OFF  = 2'd2,
        PM_WARM = 2'd3
    } pm_state_e;

    typedef struct packed {
        logic filt;
        logic osc;
        logic bias;
        logic rdy;
    } pm_out_s;

    // State requested by the configuration bits alone
    function automatic pm_state_e cfg_target(input logic pd, input logic deep);
        if (!pd)
            return PM_RUN;
        else if (deep)
            return PM_OFF;
        else
            return PM_IDLE;
    endfunction

    function automatic pm_out_s decode_outputs(input pm_state_e st);
        pm_out_s o;
        case (st)
            PM_RUN:  o = '{filt: 1'b1, osc: 1'b1, bias: 1'b1, rdy: 1'b1};
            PM_IDLE: o = '{filt: 1'b0, osc: 1'b1, bias: 1'b1, rdy: 1'b1};
            PM_OFF:  o = '{filt: 1'b0, osc: 1'b0, bias: 1'b0, rdy: 1'b0};
            default: o = '{filt: 1'b0, osc: 1'b1, bias: 1'b0, rdy: 1'b0};
        endcase
        return o;
    endfunction

endpackage

// File: rtl/pwr_wake_timer.sv
module pwr_wake_timer #(
    parameter int WAIT_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic tick,
    output logic done
);
    localparam int CW = $clog2(WAIT_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WAIT_TICKS - 1);

    logic [CW-1:0] cnt;

    // Counter is held at zero whenever warm-up is not active
    always_ff @(posedge clk) begin
        if (rst || !active)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    assign done = active && tick && (cnt == LAST);

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  pm_state_e cur,
    input  logic      pend,
    input  logic      pd,
    input  logic      deep,
    input  logic      ext_clk,
    input  logic      srst,
    input  logic      wait_done,
    output pm_state_e nxt,
    output logic      pend_nxt
);
    pm_state_e req;

    always_comb begin
        req      = cfg_target(pd, deep);
        nxt      = cur;
        pend_nxt = 1'b0;
        case (cur)
            PM_RUN, PM_IDLE: begin
                nxt = srst ? PM_RUN : req;
            end
            PM_OFF: begin
                if (srst || req != PM_OFF) begin
                    if (ext_clk) begin
                        nxt = srst ? PM_RUN : req;
                    end else begin
                        nxt      = PM_WARM;
                        pend_nxt = srst;
                    end
                end
            end
            default: begin
                if (pend || srst) begin
                    if (ext_clk || wait_done)
                        nxt = PM_RUN;
                    else
                        pend_nxt = 1'b1;
                end else if (req == PM_OFF) begin
                    nxt = PM_OFF;
                end else if (ext_clk || wait_done) begin
                    nxt = req;
                end
            end
        endcase
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int WAIT_TICKS = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_req,
    input  logic deep_sel,
    input  logic ext_clk_sel,
    input  logic soft_rst,
    input  logic ref_tick,
    output logic filt_en,
    output logic osc_en,
    output logic bias_en,
    output logic ready
);
    pm_state_e state_q, state_d;
    logic      pend_q, pend_d;
    logic      warm_done;
    pm_out_s   outs;

    pwr_wake_timer #(.WAIT_TICKS(WAIT_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .active (state_q == PM_WARM),
        .tick   (ref_tick),
        .done   (warm_done)
    );

    pwr_mode_fsm u_fsm (
        .cur       (state_q),
        .pend      (pend_q),
        .pd        (pd_req),
        .deep      (deep_sel),
        .ext_clk   (ext_clk_sel),
        .srst      (soft_rst),
        .wait_done (warm_done),
        .nxt       (state_d),
        .pend_nxt  (pend_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PM_RUN;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
        end
    end

    assign outs    = decode_outputs(state_q);
    assign filt_en = outs.filt;
    assign osc_en  = outs.osc;
    assign bias_en = outs.bias;
    assign ready   = outs.rdy;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic pd_req,
    input logic deep_sel,
    input logic ext_clk_sel,
    input logic soft_rst,
    input logic filt_en,
    input logic osc_en,
    input logic bias_en,
    input logic ready
);
    a_r1_reset_normal: assert property (@(posedge clk)
        rst |=> (filt_en && osc_en && bias_en && ready));

    a_r2_filter_needs_all: assert property (@(posedge clk) disable iff (rst)
        filt_en |-> (osc_en && bias_en && ready));

    a_r3_enter_standby: assert property (@(posedge clk) disable iff (rst)
        (filt_en && pd_req && !deep_sel && !soft_rst)
        |=> (!filt_en && osc_en && bias_en && ready));

    a_r4_enter_sleep: assert property (@(posedge clk) disable iff (rst)
        (filt_en && pd_req && deep_sel && !soft_rst)
        |=> (!filt_en && !osc_en && !bias_en && !ready));

    a_r5_sleep_exit_waits: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && !ext_clk_sel && !pd_req)
        |=> (osc_en && !ready && !bias_en && !filt_en));

    a_r6_ext_clock_skip: assert property (@(posedge clk) disable iff (rst)
        (!osc_en && ext_clk_sel && (soft_rst || !pd_req || !deep_sel))
        |=> ready);

    a_r8_soft_reset_awake: assert property (@(posedge clk) disable iff (rst)
        (osc_en && ready && soft_rst) |=> filt_en);

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pd_req      (pd_req),
    .deep_sel    (deep_sel),
    .ext_clk_sel (ext_clk_sel),
    .soft_rst    (soft_rst),
    .filt_en     (filt_en),
    .osc_en      (osc_en),
    .bias_en     (bias_en),
    .ready       (ready)
);

// File: tb/pwr_mode_ctrl_test.sv
module pwr_mode_ctrl_test;
    localparam int W = 3;
    // Expected {filt_en, osc_en, bias_en, ready}
    localparam logic [3:0] E_RUN  = 4'b1111;
    localparam logic [3:0] E_IDLE = 4'b0111;
    localparam logic [3:0] E_OFF  = 4'b0000;
    localparam logic [3:0] E_WARM = 4'b0100;

    logic clk = 1'b0;
    logic rst, pd_req, deep_sel, ext_clk_sel, soft_rst, ref_tick;
    logic filt_en, osc_en, bias_en, ready;

    int n_run  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [3:0] q_exp[$];
    string      q_tag[$];

    always #2 clk = ~clk;

    pwr_mode_ctrl #(.WAIT_TICKS(W)) uut (
        .clk(clk), .rst(rst), .pd_req(pd_req), .deep_sel(deep_sel),
        .ext_clk_sel(ext_clk_sel), .soft_rst(soft_rst), .ref_tick(ref_tick),
        .filt_en(filt_en), .osc_en(osc_en), .bias_en(bias_en), .ready(ready)
    );

    // Driver: set inputs before an edge, queue the outputs expected after it
    task automatic step(input logic r, input logic pd, input logic dp,
                        input logic ex, input logic sr, input logic tk,
                        input logic [3:0] exp, input string tag);
        @(negedge clk);
        rst = r; pd_req = pd; deep_sel = dp;
        ext_clk_sel = ex; soft_rst = sr; ref_tick = tk;
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    // Monitor: compare one item per edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q_exp.size() > 0) begin
                logic [3:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                n_run++;
                if ({filt_en, osc_en, bias_en, ready} !== e) begin
                    n_fail++;
                    $display("FAIL %s: outputs %b expected %b", t,
                             {filt_en, osc_en, bias_en, ready}, e);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, got %0d expected 0 pending", q_exp.size());
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1; pd_req = 0; deep_sel = 0; ext_clk_sel = 0; soft_rst = 0; ref_tick = 0;
        // R1: reset wins over a sleep request
        step(1, 1, 1, 0, 0, 0, E_RUN, "R1");
        step(1, 1, 1, 0, 0, 0, E_RUN, "R1");
        // R2
        step(0, 0, 0, 0, 0, 0, E_RUN, "R2");
        step(0, 0, 0, 0, 0, 1, E_RUN, "R2");
        // R3 and R9 (tick in standby ignored)
        step(0, 1, 0, 0, 0, 0, E_IDLE, "R3");
        step(0, 1, 0, 0, 0, 1, E_IDLE, "R9");
        step(0, 0, 0, 0, 0, 0, E_RUN, "R3");
        // R4
        step(0, 1, 1, 0, 0, 0, E_OFF, "R4");
        step(0, 1, 1, 0, 0, 1, E_OFF, "R9");
        // R5: three ticks, with a gap
        step(0, 0, 0, 0, 0, 0, E_WARM, "R5");
        step(0, 0, 0, 0, 0, 1, E_WARM, "R5");
        step(0, 0, 0, 0, 0, 0, E_WARM, "R9");
        step(0, 0, 0, 0, 0, 1, E_WARM, "R5");
        step(0, 0, 0, 0, 0, 1, E_RUN, "R5");
        // R6: external clock leaves sleep directly
        step(0, 1, 1, 0, 0, 0, E_OFF, "R4");
        step(0, 0, 0, 1, 0, 0, E_RUN, "R6");
        // R7: standby -> sleep direct, sleep -> standby via warm-up
        step(0, 1, 0, 0, 0, 0, E_IDLE, "R7");
        step(0, 1, 1, 0, 0, 0, E_OFF, "R7");
        step(0, 1, 0, 0, 0, 0, E_WARM, "R7");
        step(0, 1, 0, 0, 0, 1, E_WARM, "R7");
        step(0, 1, 0, 0, 0, 1, E_WARM, "R7");
        step(0, 1, 0, 0, 0, 1, E_IDLE, "R7");
        // R10: abort and restart from zero
        step(0, 1, 1, 0, 0, 0, E_OFF, "R10");
        step(0, 0, 0, 0, 0, 0, E_WARM, "R10");
        step(0, 0, 0, 0, 0, 1, E_WARM, "R10");
        step(0, 1, 1, 0, 0, 0, E_OFF, "R10");
        step(0, 0, 0, 0, 0, 0, E_WARM, "R10");
        step(0, 0, 0, 0, 0, 1, E_WARM, "R10");
        step(0, 0, 0, 0, 0, 1, E_WARM, "R10");
        step(0, 0, 0, 0, 0, 1, E_RUN, "R10");
        // R8: soft reset from standby
        step(0, 1, 0, 0, 0, 0, E_IDLE, "R8");
        step(0, 1, 0, 0, 1, 0, E_RUN, "R8");
        step(0, 0, 0, 0, 0, 0, E_RUN, "R8");
        // R8: soft reset from sleep waits, ignores sleep requests
        step(0, 1, 1, 0, 0, 0, E_OFF, "R8");
        step(0, 1, 1, 0, 1, 0, E_WARM, "R8");
        step(0, 1, 1, 0, 0, 1, E_WARM, "R8");
        step(0, 1, 1, 0, 0, 1, E_WARM, "R8");
        step(0, 0, 0, 0, 0, 1, E_RUN, "R8");
        // R6: external clock during warm-up ends it
        step(0, 1, 1, 0, 0, 0, E_OFF, "R6");
        step(0, 0, 0, 0, 0, 0, E_WARM, "R6");
        step(0, 0, 0, 1, 0, 0, E_RUN, "R6");
        step(0, 0, 0, 0, 0, 0, E_RUN, "R2");
        repeat (3) @(posedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule